// File: doc/BRIEF.md
# Clock Phase Synchronization Monitor

This block observes a 2-bit phase code that comes from the circuit which aligns two related internal clocks. When that alignment holds, the code walks around the three nonzero values in a fixed ring: 01, then 10, then 11, then back to 01. The value 00 is never part of the ring. If 00 appears, alignment has been lost.

The monitor samples the code on every edge of its clock. It keeps the four most recent samples and packs them into a single read-only diagnostic byte, with the newest sample in the top two bits. It raises a `locked` output once the ring has been followed for three transitions in a row. It also keeps a sticky `sync_lost` flag, which records a 00 that arrives while the monitor is locked. Software or a supervisor clears that flag with a one-cycle `lost_clr` pulse.

Top module: `phase_sync_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `hist_byte` = 0x00, `locked` = 0 and `sync_lost` = 0.
- R2: After every clock edge, `hist_byte[7:6]` holds the `phase_in` value sampled at that edge.
- R3: After every clock edge, `hist_byte[5:4]`, `[3:2]` and `[1:0]` hold the samples taken one, two and three edges earlier, so the byte shifts down by two bits per edge.
- R4: A transition is correct when the new sample is the ring successor of the previous sample (01→10, 10→11, 11→01) and neither sample is 00. `locked` rises after the edge that completes the third consecutive correct transition. It is still low after the second.
- R5: A nonzero sample that is not the successor of the previous sample drops `locked` after that edge and leaves `sync_lost` unchanged. Counting for a new lock starts from that sample.
- R6: A 00 sample drops `locked` after that edge. If `locked` was high before that edge, `sync_lost` is 1 after it.
- R7: `sync_lost` stays high until an edge where `lost_clr` is 1. When a new loss and `lost_clr` occur at the same edge, the flag stays set.
- R8: A 00 sample while `locked` is low does not set `sync_lost`.
- R9: `locked` stays high for as long as every new sample continues the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_in | input | 2 | Phase code from the clock alignment circuit |
| lost_clr | input | 1 | Clears the sticky loss flag |
| hist_byte | output | 8 | Newest sample in [7:6], oldest in [1:0] |
| locked | output | 1 | Ring followed for three consecutive transitions |
| sync_lost | output | 1 | Sticky: a 00 was seen while locked |

## Verification
The hardest case to reach is a loss that happens at the same edge as a clear pulse. It needs the monitor already locked, a 00 on `phase_in`, and `lost_clr` high, all in one cycle. Directed sequences first build a lock from a clean ring, then apply that combination, and also break the ring with out-of-order nonzero codes. Random stimulus then follows the ring most of the time and injects wrong codes, zeros and clears at a low rate, so that locks, losses and clears recur many times.

// File: rtl/psm_pkg.sv
// Package: shared constants and the phase ring arithmetic.
// Assumes the phase code is PHASE_W bits wide and that code 0 is outside the ring.
package psm_pkg;
    localparam int PHASE_W = 2;

    // Ring successor of a nonzero code: the code counts upward and wraps from all-ones back to 1.
    function automatic logic [PHASE_W-1:0] phase_succ(input logic [PHASE_W-1:0] c);
        return (c == '1) ? PHASE_W'(1) : PHASE_W'(c + 1'b1);
    endfunction

    // True when cur correctly follows prev on the ring.
    function automatic logic phase_step_ok(input logic [PHASE_W-1:0] prev,
                                           input logic [PHASE_W-1:0] cur);
        return (prev != '0) && (cur != '0) && (cur == phase_succ(prev));
    endfunction
endpackage

// File: rtl/psm_history.sv
// Module: a DEPTH-deep shift register of phase samples, packed with the newest at the MSB.
// Assumes a synchronous active-low reset that clears every slot to 0.
module psm_history #(
    parameter int DEPTH  = 4,
    localparam int PW     = psm_pkg::PHASE_W,
    localparam int STAT_W = DEPTH * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     sample,
    output logic [PW-1:0]     newest,
    output logic [STAT_W-1:0] packed_hist
);
    logic [PW-1:0] slot [DEPTH];

    // Shift all slots by one position on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            slot[0] <= sample;
            for (int i = 1; i < DEPTH; i++) slot[i] <= slot[i-1];
        end
    end

    // Pack the slots: slot 0 (newest) goes to the top of the byte.
    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
        assign packed_hist[STAT_W-1-g*PW -: PW] = slot[g];
    end

    assign newest = slot[0];
endmodule

// File: rtl/psm_lock_tracker.sv
// Module: counts consecutive correct ring transitions and asserts the lock once the count reaches LOCK_RUN.
// Assumes prev is the sample registered at the previous edge (0 right after reset).
module psm_lock_tracker #(
    parameter int LOCK_RUN = 3,
    localparam int PW    = psm_pkg::PHASE_W,
    localparam int RUN_W = $clog2(LOCK_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] sample,
    input  logic [PW-1:0] prev,
    output logic          locked
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    // Next count: extend on a correct step and saturate; any other sample restarts the count.
    always_comb begin
        if (psm_pkg::phase_step_ok(prev, sample)) begin
            run_d = (run_q == RUN_W'(LOCK_RUN)) ? run_q : RUN_W'(run_q + 1'b1);
        end else begin
            run_d = '0;
        end
    end

    // Register the run length.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign locked = (run_q == RUN_W'(LOCK_RUN));
endmodule

// File: rtl/psm_loss_flag.sv
// Module: sticky loss-of-sync flag, set by a zero sample while locked and cleared by a pulse.
// Assumes locked is the state before the current edge; a set wins over a clear at the same edge.
module psm_loss_flag #(
    localparam int PW = psm_pkg::PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] sample,
    input  logic          locked,
    input  logic          clr,
    output logic          flag
);
    logic set_evt;

    // A loss is a zero code arriving while the ring was locked.
    assign set_evt = locked && (sample == '0);

    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/phase_sync_monitor.sv
// Module: top of the phase synchronization monitor. Samples the phase code every edge and
// exposes the packed history, the lock state and the sticky loss flag.
// Assumes phase_in is synchronous to clk.
module phase_sync_monitor #(
    parameter int DEPTH    = 4,
    parameter int LOCK_RUN = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [psm_pkg::PHASE_W-1:0]            phase_in,
    input  logic                                   lost_clr,
    output logic [DEPTH*psm_pkg::PHASE_W-1:0]      hist_byte,
    output logic                                   locked,
    output logic                                   sync_lost
);
    localparam int PW = psm_pkg::PHASE_W;

    logic [PW-1:0] newest;

    psm_history #(.DEPTH(DEPTH)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (phase_in),
        .newest      (newest),
        .packed_hist (hist_byte)
    );

    psm_lock_tracker #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (phase_in),
        .prev   (newest),
        .locked (locked)
    );

    psm_loss_flag u_loss (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (phase_in),
        .locked (locked),
        .clr    (lost_clr),
        .flag   (sync_lost)
    );
endmodule

// File: rtl/phase_sync_monitor_chk.sv
// Checker: temporal properties on the monitor's ports, attached to the top module by bind.
module phase_sync_monitor_chk #(
    parameter int DEPTH = 4,
    localparam int PW     = psm_pkg::PHASE_W,
    localparam int STAT_W = DEPTH * PW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PW-1:0]     phase_in,
    input logic              lost_clr,
    input logic [STAT_W-1:0] hist_byte,
    input logic              locked,
    input logic              sync_lost
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (hist_byte == '0 && !locked && !sync_lost));

    p_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hist_byte[STAT_W-1 -: PW] == $past(phase_in));

    p_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hist_byte[STAT_W-PW-1:0] == $past(hist_byte[STAT_W-1:PW]));

    p_break_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !psm_pkg::phase_step_ok(hist_byte[STAT_W-1 -: PW], phase_in) |=> !locked);

    p_loss_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && phase_in == '0) |=> sync_lost);

    p_loss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost && !lost_clr) |=> sync_lost);

    p_no_false_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_lost && !(locked && phase_in == '0)) |=> !sync_lost);

    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && psm_pkg::phase_step_ok(hist_byte[STAT_W-1 -: PW], phase_in)) |=> locked);
endmodule

bind phase_sync_monitor phase_sync_monitor_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_in  (phase_in),
    .lost_clr  (lost_clr),
    .hist_byte (hist_byte),
    .locked    (locked),
    .sync_lost (sync_lost)
);

// File: tb/phase_sync_monitor_tb.sv
`timescale 1ns/1ps
module phase_sync_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_in = 2'b00;
    logic       lost_clr = 1'b0;
    logic [7:0] hist_byte;
    logic       locked;
    logic       sync_lost;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    logic [7:0] m_hist = 8'h00;
    int         m_run  = 0;
    logic       m_loss = 1'b0;

    always #2.5 clk = ~clk;

    phase_sync_monitor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phase_in),
        .lost_clr  (lost_clr),
        .hist_byte (hist_byte),
        .locked    (locked),
        .sync_lost (sync_lost)
    );

    function automatic logic [1:0] succ(input logic [1:0] c);
        return (c == 2'b11) ? 2'b01 : c + 2'b01;
    endfunction

    function automatic logic good_step(input logic [1:0] p, input logic [1:0] c);
        return (p != 2'b00) && (c != 2'b00) && (c == succ(p));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string lk_tag, input string loss_tag);
        check("R2", {6'b0, hist_byte[7:6]}, {6'b0, m_hist[7:6]});
        check("R3", {2'b0, hist_byte[5:0]}, {2'b0, m_hist[5:0]});
        check(lk_tag, {7'b0, locked}, {7'b0, (m_run == 3)});
        check(loss_tag, {7'b0, sync_lost}, {7'b0, m_loss});
    endtask

    // Apply one sample, update the model for that edge, then compare just after it.
    task automatic step(input logic [1:0] ph, input logic clr, input string lk_tag, input string loss_tag);
        logic was_locked;
        @(negedge clk);
        phase_in = ph;
        lost_clr = clr;
        @(posedge clk);
        was_locked = (m_run == 3);
        if (!rst_n) begin
            m_hist = 8'h00; m_run = 0; m_loss = 1'b0;
        end else begin
            m_run = good_step(m_hist[7:6], ph) ? ((m_run < 3) ? m_run + 1 : 3) : 0;
            if (ph == 2'b00 && was_locked) m_loss = 1'b1;
            else if (clr)                  m_loss = 1'b0;
            m_hist = {ph, m_hist[7:2]};
        end
        #1;
        compare(lk_tag, loss_tag);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [1:0] ph;
        void'($urandom(32'h5EED_0042));
        // R1: reset state, with nonzero stimulus held during reset
        step(2'b11, 1'b0, "R1", "R1");
        step(2'b01, 1'b0, "R1", "R1");
        rst_n = 1'b1;
        // R4: lock after the third correct transition, not before
        step(2'b01, 1'b0, "R4", "R8");
        step(2'b10, 1'b0, "R4", "R8");
        step(2'b11, 1'b0, "R4", "R8");
        check("R4", {7'b0, locked}, 8'h00);
        step(2'b01, 1'b0, "R4", "R8");
        check("R4", {7'b0, locked}, 8'h01);
        // R9: lock held while the ring continues
        step(2'b10, 1'b0, "R9", "R7");
        step(2'b11, 1'b0, "R9", "R7");
        check("R9", {7'b0, locked}, 8'h01);
        // R5: out-of-order nonzero drops lock, no loss flag
        step(2'b10, 1'b0, "R5", "R5");
        check("R5", {6'b0, sync_lost, locked}, 8'h00);
        step(2'b11, 1'b0, "R5", "R5");
        step(2'b01, 1'b0, "R5", "R5");
        step(2'b10, 1'b0, "R5", "R5");
        check("R5", {7'b0, locked}, 8'h01);
        // R6: zero while locked sets loss, drops lock
        step(2'b00, 1'b0, "R6", "R6");
        check("R6", {6'b0, sync_lost, locked}, 8'h02);
        // R7: stays set, then clear
        step(2'b01, 1'b0, "R7", "R7");
        check("R7", {7'b0, sync_lost}, 8'h01);
        step(2'b00, 1'b1, "R7", "R7");
        check("R7", {7'b0, sync_lost}, 8'h00);
        // R8: zero while unlocked does nothing to the flag
        step(2'b00, 1'b0, "R8", "R8");
        check("R8", {7'b0, sync_lost}, 8'h00);
        // R7: loss and clear together keep the flag set
        step(2'b11, 1'b0, "R4", "R8");
        step(2'b01, 1'b0, "R4", "R8");
        step(2'b10, 1'b0, "R4", "R8");
        step(2'b11, 1'b0, "R4", "R8");
        step(2'b00, 1'b1, "R6", "R7");
        check("R7", {7'b0, sync_lost}, 8'h01);
        // R3: a known four-sample pattern lands in place
        step(2'b01, 1'b0, "R4", "R7");
        step(2'b11, 1'b0, "R5", "R7");
        step(2'b10, 1'b0, "R5", "R7");
        check("R3", hist_byte, 8'b10_11_01_00);
        // Random phase: mostly follow the ring, sometimes inject faults and clears
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) < 8) ph = succ(m_hist[7:6]);
            else ph = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) begin
                rst_n = 1'b0;
                step(ph, 1'b0, "R1", "R1");
                rst_n = 1'b1;
            end else begin
                step(ph, ($urandom_range(0, 19) == 0), "R4", "R7");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule